// File: doc/BRIEF.md
# Calibratable 24-Hour BCD Timekeeper

This block keeps the time of day as six binary-coded decimal digits: a tens and a ones digit each for seconds, minutes and hours. All state sits on one system clock. A one-cycle 1 Hz timing enable advances the seconds. A wrap of the seconds carries into the minutes, and a wrap of the minutes carries into the hours. The hours run from 00 to 23. While the hour tens digit is 0 or 1, the hour ones digit runs through 0 to 9. While the hour tens digit is 2, the ones digit stops at 3, and the field then returns to 00.

Two debounced key levels set the clock. Each rising edge of the mode key moves the block one step through the sequence: running, hour set, minute set, second set, and back to running. In a set state the 1 Hz enable has no effect. While the advance key is held, each one-cycle 2 Hz calibration enable steps the selected field by one. The field wraps within its own range, carries into no other field, and the other two fields keep their values. The frequency divider that produces the enables is outside this block, and so is the display drive.

Top module: `tk_timekeeper`

## Requirements
- R1: An active-low `rst_n` clears all six digits to 0 and sets `mode` to 0 (running) without waiting for a clock edge.
- R2: In running mode (`mode` = 0), each clock cycle with `tick_1hz` high advances the seconds by one, through 00 to 59. A cycle without `tick_1hz` changes no digit.
- R3: In running mode, a seconds wrap from 59 to 00 adds one to the minutes. A minutes wrap from 59 to 00 that happens together with a seconds wrap adds one to the hours.
- R4: The hour field counts 00 to 23. The ones digit reaches 9 while the tens digit is 0 or 1, reaches only 3 while the tens digit is 2, and the field then returns to 00.
- R5: Each rising edge of `mode_key` moves `mode` one step through the codes 0 (running), 1 (hour set), 2 (minute set), 3 (second set), and then back to 0. `mode` changes in the cycle after the edge. Holding the key high for several cycles gives a single step.
- R6: In a set mode, a cycle with both `tick_2hz` and `adv_key` high advances the selected field by one. A `tick_1hz` alone, or a `tick_2hz` without `adv_key`, changes no digit.
- R7: In a set mode, the selected field wraps within its own range (59 to 00, or 23 to 00) with no carry. The two fields that are not selected keep their values.
- R8: In running mode, `tick_2hz` and `adv_key` have no effect on any digit.
- R9: When a `mode_key` rising edge and an enable fall in the same cycle, the enable is acted on under the mode that held before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle timing enable, once per second |
| tick_2hz | input | 1 | One-cycle calibration enable, twice per second |
| mode_key | input | 1 | Debounced mode key level; acts on its rising edge |
| adv_key | input | 1 | Debounced advance key level; lets calibration enables reach the selected field |
| sec_ones | output | 4 | Seconds ones digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| min_ones | output | 4 | Minutes ones digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| hr_ones | output | 4 | Hours ones digit, BCD |
| hr_tens | output | 4 | Hours tens digit, BCD |
| mode | output | 2 | Current mode: 0 running, 1 hour set, 2 minute set, 3 second set |

## Verification
Two pairs of events can land in the same cycle. The first is a mode-key edge together with a counting enable. The bench raises `mode_key` in the same cycle as `tick_1hz` in running mode, and in the same cycle as `tick_2hz` with `adv_key` in hour-set mode. It expects the count to follow the old mode and the mode to step once. The second is the seconds and minutes wraps arriving on one 1 Hz enable. The bench calibrates the time to 23:59:58 and then checks, tick by tick, that the following ticks give 23:59:59 and then 00:00:00.

// File: rtl/tk_pkg.sv
// Package: shared types and field limits for the BCD timekeeper.
// Assumes every digit is a 4-bit BCD value, and that the mode codes are
// numbered in the order the mode key visits them.
package tk_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] bcd_t;

    // Mode codes; each increment is one step of the sequence
    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_HOUR = 2'd1,
        MODE_MIN  = 2'd2,
        MODE_SEC  = 2'd3
    } tk_mode_e;

    // Field indices used in the field array
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int NUM_FIELDS = 3;

    // Last tens digit and last ones digit (at that tens digit) per field
    localparam int SIXTY_TENS_LAST = 5;
    localparam int SIXTY_ONES_LAST = 9;
    localparam int DAY_TENS_LAST   = 2;
    localparam int DAY_ONES_LAST   = 3;

    function automatic int field_tens_last(input int idx);
        return (idx == F_HOUR) ? DAY_TENS_LAST : SIXTY_TENS_LAST;
    endfunction

    function automatic int field_ones_last(input int idx);
        return (idx == F_HOUR) ? DAY_ONES_LAST : SIXTY_ONES_LAST;
    endfunction

endpackage

// File: rtl/tk_rise_detect.sv
// Module: one-cycle pulse on the rising edge of a level input.
// Assumes the level is already debounced and synchronous to clk. After
// reset the level is taken as previously low.
module tk_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);

    logic level_q;

    // Keep last cycle's level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    // Low-to-high transition seen this cycle
    always_comb pulse = level & ~level_q;

endmodule

// File: rtl/tk_mode_seq.sv
// Module: four-state mode sequencer for running and the three set states.
// Assumes step is a single-cycle pulse. Each pulse advances the mode once,
// and the code wraps from second set back to running.
module tk_mode_seq
    import tk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    output tk_mode_e mode
);

    // Advance the mode on each step pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mode <= MODE_RUN;
        else if (step) mode <= tk_mode_e'(mode + 2'd1);
    end

endmodule

// File: rtl/tk_step_ctrl.sv
// Module: decides which time fields advance in the current cycle.
// Assumes both enables are one-cycle pulses. In running mode only the
// timing enable counts and carries ripple upward. In a set mode only the
// calibration enable qualified by the advance key counts, for the
// selected field alone.
module tk_step_ctrl
    import tk_pkg::*;
(
    input  tk_mode_e               mode,
    input  logic                   tick_1hz,
    input  logic                   tick_2hz,
    input  logic                   adv_key,
    input  bcd_t                   sec_tens,
    input  bcd_t                   sec_ones,
    input  bcd_t                   min_tens,
    input  bcd_t                   min_ones,
    output logic [NUM_FIELDS-1:0]  inc
);

    localparam bcd_t S_TENS_LAST = bcd_t'(SIXTY_TENS_LAST);
    localparam bcd_t S_ONES_LAST = bcd_t'(SIXTY_ONES_LAST);

    logic sec_full;
    logic min_full;
    logic cal_go;
    logic running;

    // Field-at-limit flags that create carries
    always_comb begin
        sec_full = (sec_tens == S_TENS_LAST) && (sec_ones == S_ONES_LAST);
        min_full = (min_tens == S_TENS_LAST) && (min_ones == S_ONES_LAST);
    end

    // Mode and calibration qualifiers
    always_comb begin
        running = (mode == MODE_RUN);
        cal_go  = tick_2hz & adv_key;
    end

    // Per-field increment selection
    always_comb begin
        if (running) begin
            inc[F_SEC]  = tick_1hz;
            inc[F_MIN]  = tick_1hz & sec_full;
            inc[F_HOUR] = tick_1hz & sec_full & min_full;
        end else begin
            inc[F_SEC]  = cal_go & (mode == MODE_SEC);
            inc[F_MIN]  = cal_go & (mode == MODE_MIN);
            inc[F_HOUR] = cal_go & (mode == MODE_HOUR);
        end
    end

endmodule

// File: rtl/tk_bcd_field.sv
// Module: two-digit BCD counter with a configurable final value.
// Assumes the ones digit runs 0..9 for every tens digit below TENS_LAST.
// At TENS_LAST it runs only to ONES_LAST, and the field then returns
// to 00. It advances once on each cycle with inc high.
module tk_bcd_field
    import tk_pkg::*;
#(
    parameter int TENS_LAST = 5,
    parameter int ONES_LAST = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output bcd_t tens,
    output bcd_t ones
);

    localparam bcd_t TENS_L = bcd_t'(TENS_LAST);
    localparam bcd_t ONES_L = bcd_t'(ONES_LAST);
    localparam bcd_t NINE   = bcd_t'(9);

    bcd_t ones_top;

    // Highest ones value allowed under the present tens digit
    always_comb ones_top = (tens == TENS_L) ? ONES_L : NINE;

    // Count with decimal carry from ones into tens, and wrap at the end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tens <= '0;
            ones <= '0;
        end else if (inc) begin
            if (ones == ones_top) begin
                ones <= '0;
                tens <= (tens == TENS_L) ? '0 : tens + bcd_t'(1);
            end else begin
                ones <= ones + bcd_t'(1);
            end
        end
    end

endmodule

// File: rtl/tk_timekeeper.sv
// Module: top of the calibratable 24-hour BCD timekeeper.
// Assumes tick_1hz and tick_2hz are one-cycle enables on clk, and that
// mode_key and adv_key are debounced levels synchronous to clk.
// The reset is asynchronous and active low.
module tk_timekeeper
    import tk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       tick_2hz,
    input  logic       mode_key,
    input  logic       adv_key,
    output logic [3:0] sec_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] min_ones,
    output logic [3:0] min_tens,
    output logic [3:0] hr_ones,
    output logic [3:0] hr_tens,
    output logic [1:0] mode
);

    logic                  mode_step;
    tk_mode_e              cur_mode;
    logic [NUM_FIELDS-1:0] inc;
    bcd_t                  f_tens [NUM_FIELDS];
    bcd_t                  f_ones [NUM_FIELDS];

    tk_rise_detect u_mode_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (mode_key),
        .pulse (mode_step)
    );

    tk_mode_seq u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (mode_step),
        .mode  (cur_mode)
    );

    tk_step_ctrl u_ctrl (
        .mode     (cur_mode),
        .tick_1hz (tick_1hz),
        .tick_2hz (tick_2hz),
        .adv_key  (adv_key),
        .sec_tens (f_tens[F_SEC]),
        .sec_ones (f_ones[F_SEC]),
        .min_tens (f_tens[F_MIN]),
        .min_ones (f_ones[F_MIN]),
        .inc      (inc)
    );

    // One counter per field, limits chosen by field index
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        tk_bcd_field #(
            .TENS_LAST (field_tens_last(g)),
            .ONES_LAST (field_ones_last(g))
        ) u_field (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[g]),
            .tens  (f_tens[g]),
            .ones  (f_ones[g])
        );
    end

    // Drive the digit and mode outputs
    always_comb begin
        sec_ones = f_ones[F_SEC];
        sec_tens = f_tens[F_SEC];
        min_ones = f_ones[F_MIN];
        min_tens = f_tens[F_MIN];
        hr_ones  = f_ones[F_HOUR];
        hr_tens  = f_tens[F_HOUR];
        mode     = cur_mode;
    end

endmodule

// File: rtl/tk_timekeeper_chk.sv
// Module: property checker bound to the timekeeper top. It observes
// ports only.
module tk_timekeeper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic       tick_2hz,
    input logic       adv_key,
    input logic [3:0] sec_ones,
    input logic [3:0] sec_tens,
    input logic [3:0] min_ones,
    input logic [3:0] min_tens,
    input logic [3:0] hr_ones,
    input logic [3:0] hr_tens,
    input logic [1:0] mode
);

    logic [23:0] digits;
    assign digits = {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones};

    // R2
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tens <= 4'd5) && (sec_ones <= 4'd9));

    // R4
    hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_ones <= 4'd9) && ((hr_tens < 4'd2) || (hr_tens == 4'd2 && hr_ones <= 4'd3)));

    // R5
    mode_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mode == $past(mode)) || (mode == $past(mode) + 2'd1));

    // R2
    run_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && !tick_1hz) |=> $stable(digits));

    // R6
    set_no_cal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && !(tick_2hz && adv_key)) |=> $stable(digits));

    // R7
    hour_set_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |=> $stable(digits[15:0]));

    // R7
    sec_set_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> $stable(digits[23:8]));

    // R3
    midnight_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && tick_1hz && digits == 24'h235959) |=> (digits == 24'h000000));

endmodule

bind tk_timekeeper tk_timekeeper_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .tick_2hz (tick_2hz),
    .adv_key  (adv_key),
    .sec_ones (sec_ones),
    .sec_tens (sec_tens),
    .min_ones (min_ones),
    .min_tens (min_tens),
    .hr_ones  (hr_ones),
    .hr_tens  (hr_tens),
    .mode     (mode)
);

// File: tb/tk_timekeeper_tb.sv
// Scoreboard bench. The driver task applies one cycle of stimulus,
// advances a behavioural model and queues the expected outputs. The
// monitor pops one item after each clock edge and compares.
module tk_timekeeper_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_1hz, tick_2hz, mode_key, adv_key;
    logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;
    logic [1:0] mode;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Behavioural model state
    int m_sec, m_min, m_hr, m_mode;
    bit m_prev_key;
    string cur_tag = "R1";

    logic [25:0] q_val [$];
    string       q_tag [$];

    tk_timekeeper u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_2hz(tick_2hz),
        .mode_key(mode_key), .adv_key(adv_key),
        .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones),
        .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens), .mode(mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [25:0] model_word();
        return {2'(m_mode), to_bcd(m_hr), to_bcd(m_min), to_bcd(m_sec)};
    endfunction

    function automatic logic [25:0] dut_word();
        return {mode, hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones};
    endfunction

    task automatic check(input string tag, input logic [25:0] act, input logic [25:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual mode=%0d time=%h expected mode=%0d time=%h",
                     tag, act[25:24], act[23:0], exp[25:24], exp[23:0]);
        end
    endtask

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hr = 0; m_mode = 0; m_prev_key = 1'b0;
    endtask

    // Driver: one cycle of stimulus, model update, expected item queued
    task automatic step(input bit t1, input bit t2, input bit mk, input bit ak);
        bit edge_seen;
        @(negedge clk);
        tick_1hz = t1; tick_2hz = t2; mode_key = mk; adv_key = ak;
        edge_seen = mk && !m_prev_key;
        m_prev_key = mk;
        if (m_mode == 0) begin
            if (t1) begin
                m_sec++;
                if (m_sec == 60) begin
                    m_sec = 0; m_min++;
                    if (m_min == 60) begin
                        m_min = 0; m_hr = (m_hr + 1) % 24;
                    end
                end
            end
        end else if (t2 && ak) begin
            if (m_mode == 1) m_hr  = (m_hr + 1) % 24;
            if (m_mode == 2) m_min = (m_min + 1) % 60;
            if (m_mode == 3) m_sec = (m_sec + 1) % 60;
        end
        if (edge_seen) m_mode = (m_mode + 1) % 4;
        q_val.push_back(model_word());
        q_tag.push_back(cur_tag);
    endtask

    // Monitor: compare after each clock edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q_val.size() > 0) begin
                logic [25:0] e;
                string t;
                e = q_val.pop_front();
                t = q_tag.pop_front();
                check(t, dut_word(), e);
            end
        end
    end

    task automatic press_mode(input int hold);
        for (int i = 0; i < hold; i++) step(0, 0, 1, 0);
        step(0, 0, 0, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        tick_1hz = 0; tick_2hz = 0; mode_key = 0; adv_key = 0;
        model_reset();
        repeat (2) @(negedge clk);
        check("R1", dut_word(), 26'h0);
        rst_n = 1'b1;

        // R2 R3: run 65 seconds with idle gaps, crossing a minute carry
        cur_tag = "R2";
        for (int i = 0; i < 65; i++) begin
            step(1, 0, 0, 0);
            step(0, 0, 0, 0);
        end

        // R5: into hour set
        cur_tag = "R5";
        press_mode(1);

        // R6: ignored stimuli in a set mode
        cur_tag = "R6";
        step(1, 0, 0, 1);
        step(0, 1, 0, 0);
        step(0, 0, 0, 1);

        // R4 R7: hour calibration through the 23 to 00 wrap, ending at 23
        cur_tag = "R4";
        for (int i = 0; i < 47; i++) begin
            step(0, 1, 0, 1);
            step(0, 0, 0, 1);
        end

        // R5: held key gives one step, into minute set
        cur_tag = "R5";
        press_mode(5);

        // R7: minute field wraps without carrying into hours
        cur_tag = "R7";
        for (int i = 0; i < 118; i++) step(0, 1, 0, 1);

        cur_tag = "R5";
        press_mode(3);

        // R7: second field to 58, passing a wrap, others held
        cur_tag = "R7";
        for (int i = 0; i < 113; i++) step(0, 1, 0, 1);

        // R9: press together with 1 Hz in second set; tick ignored, mode back to run
        cur_tag = "R9";
        step(1, 0, 1, 0);
        step(0, 0, 0, 0);

        // R8: calibration stimulus in running mode
        cur_tag = "R8";
        step(0, 1, 0, 1);
        step(0, 1, 1, 1);
        step(0, 0, 0, 0);
        // back to run: three more presses
        cur_tag = "R5";
        press_mode(1);
        press_mode(1);
        press_mode(1);

        // R3 R4: 23:59:58 -> 23:59:59 -> 00:00:00
        cur_tag = "R3";
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);

        // R9: press with 1 Hz in run: second counts and mode goes to hour set
        cur_tag = "R9";
        step(1, 0, 1, 0);
        step(0, 0, 0, 0);
        // R9: press with calibration in hour set: hour counts and mode goes to minute set
        step(0, 1, 1, 1);
        step(0, 0, 0, 0);
        step(0, 1, 0, 1);

        // R1: asynchronous reset between edges
        cur_tag = "R1";
        step(0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        model_reset();
        check("R1", dut_word(), 26'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule